// File: doc/BRIEF.md
# Streaming Impulse Noise Filter

This block cleans salt-and-pepper noise from a grayscale image stream. Pixels arrive one per transfer in raster order on an 8-bit valid/ready input. Leave the corrupted pixels on a matching valid/ready output, each one replaced by the median of its 3x3 neighbourhood. Every other pixel leaves untouched. The image size is fixed by the parameters `IMG_W` and `IMG_H`.

Noise is found by a simplified pulse-coupled neuron model with one neuron per pixel. Each neuron starts with a high dynamic threshold, so only near-saturated pixels fire in the first iteration. An optional second iteration lowers the threshold by a step. In that iteration the pixel's stimulus is raised by a linking term, which is the number of fired neighbours times a weight. Dark impulses go through the same detector on inverted pixels (255 minus value). A pixel is marked as noise when either polarity fires.

The detector settings are the threshold, step, linking weight and the choice of one or two iterations. They are sampled when the first pixel of a frame is accepted. A four-row buffer supplies the 3x3 window, and a three-stage pipeline follows it. Output row markers flag the first pixel of the frame and the last pixel of each row.

Top module: `impulse_denoise`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A pixel whose neuron fires in neither polarity is output with exactly its input value.
- R3: A pixel whose value is at least the sampled threshold fires in the first iteration. It is output as the median of the nine values in its 3x3 window.
- R4: A pixel whose inverted value (255 minus value) is at least the threshold is also replaced by the 3x3 median.
- R5: The second iteration runs only when `cfg_two_pass` is 1. In that iteration a not-yet-fired pixel fires when its stimulus reaches the threshold minus `cfg_step` (floored at 0). The stimulus is its value (or inverted value) plus `cfg_link` times the count of its 8 neighbours that fired in the first iteration with the same polarity.
- R6: Window positions outside the image take the nearest in-image pixel, with the row and the column clamped separately. This applies to both the median and the neighbour count.
- R7: `out_sof` is 1 exactly on the output pixel at row 0, column 0. `out_eol` is 1 exactly on each pixel in column `IMG_W-1`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sof` and `out_eol` hold their values.
- R9: The configuration inputs are captured when the first pixel of a frame is accepted. Changing them later in the frame has no effect on that frame.
- R10: Each frame yields exactly `IMG_W*IMG_H` outputs in raster order. The count of outputs never exceeds the count of accepted inputs. Input for the next frame is accepted only after the current frame has been fully delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | 8 | Initial neuron threshold |
| cfg_step | input | 8 | Threshold decrement for the second iteration |
| cfg_link | input | 8 | Linking weight per fired neighbour |
| cfg_two_pass | input | 1 | 1 selects two iterations, 0 selects one |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | 8 | Input pixel value |
| out_ready | input | 1 | Downstream can take a pixel |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Filtered pixel value |
| out_sof | output | 1 | First pixel of the frame |
| out_eol | output | 1 | Last pixel of a row |

## Verification
Output pixel (r,c) can be produced only after the input at row min(r+1,H-1), column min(c+1,W-1) has been accepted. It reaches the output port three unstalled cycles later. Exact timing therefore shifts with input gaps and output stalls. For that reason the bench predicts only the value and order of each result. It compares each pixel when it is transferred, whatever cycle that falls in. The one timing rule checked cycle by cycle is the stall case: every cycle in which a pixel was offered and refused is followed by a comparison against the value held from the cycle before.

// File: rtl/impulse_denoise.sv
`timescale 1ns/1ps
module impulse_denoise #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_thresh,
  input  logic [7:0] cfg_step,
  input  logic [7:0] cfg_link,
  input  logic       cfg_two_pass,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eol
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H + 1);
  localparam logic [CW-1:0] LAST_C = CW'(IMG_W - 1);
  localparam logic [RW-1:0] LAST_R = RW'(IMG_H - 1);
  localparam logic [RW-1:0] ROWS   = RW'(IMG_H);

  function automatic logic [7:0] mn(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? a : b;
  endfunction
  function automatic logic [7:0] mx(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? b : a;
  endfunction
  function automatic logic [7:0] med3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return mx(mn(a, b), mn(mx(a, b), c));
  endfunction

  function automatic logic fires(input logic [8:0][7:0] w, input logic inv,
                                 input logic [7:0] th, input logic [7:0] st,
                                 input logic [7:0] lk, input logic two);
    logic [7:0]  p;
    logic [3:0]  cnt;
    logic [7:0]  th1;
    logic [12:0] stim;
    cnt = '0;
    for (int k = 0; k < 9; k++) begin
      if (k != 4) begin
        p = inv ? ~w[k] : w[k];
        if (p >= th) cnt = cnt + 4'd1;
      end
    end
    p    = inv ? ~w[4] : w[4];
    th1  = (th > st) ? th - st : 8'd0;
    stim = 13'(p) + 13'(cnt) * 13'(lk);
    return (p >= th) || (two && (stim >= 13'(th1)));
  endfunction

  logic [7:0]    lines [4][IMG_W];
  logic [RW-1:0] irow, orow;
  logic [CW-1:0] icol, ocol;
  logic [7:0]    th_q, step_q, link_q;
  logic          two_q;
  logic          v1, v2, v3;

  logic          in_all, iss_all, in_fire, adv, have, issue, flush;
  logic [RW-1:0] need_r;
  logic [CW-1:0] need_c;
  logic [RW-1:0] rsel [3];
  logic [CW-1:0] csel [3];

  assign in_all   = (irow == ROWS);
  assign iss_all  = (orow == ROWS);
  assign in_ready = !in_all && (int'(irow) <= int'(orow) + 2);
  assign in_fire  = in_valid && in_ready;
  assign adv      = !v3 || out_ready;
  assign need_r   = (orow == LAST_R) ? orow : orow + RW'(1);
  assign need_c   = (ocol == LAST_C) ? ocol : ocol + CW'(1);
  assign have     = in_all || (irow > need_r) || (irow == need_r && icol > need_c);
  assign issue    = !iss_all && have;
  assign flush    = in_all && iss_all && !v1 && !v2 && !v3;

  assign rsel[0] = (orow == '0) ? orow : orow - RW'(1);
  assign rsel[1] = orow;
  assign rsel[2] = need_r;
  assign csel[0] = (ocol == '0) ? ocol : ocol - CW'(1);
  assign csel[1] = ocol;
  assign csel[2] = need_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irow <= '0; icol <= '0; orow <= '0; ocol <= '0;
      th_q <= '0; step_q <= '0; link_q <= '0; two_q <= 1'b0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
    end else begin
      if (flush) begin
        irow <= '0; icol <= '0; orow <= '0; ocol <= '0;
      end else begin
        if (in_fire) begin
          if (irow == '0 && icol == '0) begin
            th_q <= cfg_thresh; step_q <= cfg_step;
            link_q <= cfg_link; two_q <= cfg_two_pass;
          end
          if (icol == LAST_C) begin
            icol <= '0; irow <= irow + RW'(1);
          end else icol <= icol + CW'(1);
        end
        if (issue && adv) begin
          if (ocol == LAST_C) begin
            ocol <= '0; orow <= orow + RW'(1);
          end else ocol <= ocol + CW'(1);
        end
      end
      if (adv) begin
        v1 <= issue; v2 <= v1; v3 <= v2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) lines[irow[1:0]][icol] <= in_data;
  end

  logic [8:0][7:0]      win;
  logic                 sof1, eol1, sof2, eol2, flag2;
  logic [7:0]           ctr2;
  logic [2:0][2:0][7:0] srt;
  logic [7:0]           med;

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          win[r*3+c] <= lines[rsel[r][1:0]][csel[c]];
      sof1 <= (orow == '0) && (ocol == '0);
      eol1 <= (ocol == LAST_C);

      for (int c = 0; c < 3; c++) begin
        srt[c][0] <= mn(mn(win[c], win[3+c]), win[6+c]);
        srt[c][1] <= med3(win[c], win[3+c], win[6+c]);
        srt[c][2] <= mx(mx(win[c], win[3+c]), win[6+c]);
      end
      flag2 <= fires(win, 1'b0, th_q, step_q, link_q, two_q) ||
               fires(win, 1'b1, th_q, step_q, link_q, two_q);
      ctr2  <= win[4];
      sof2  <= sof1;
      eol2  <= eol1;

      out_data <= flag2 ? med : ctr2;
      out_sof  <= sof2;
      out_eol  <= eol2;
    end
  end

  assign med = med3(mx(mx(srt[0][0], srt[1][0]), srt[2][0]),
                    med3(srt[0][1], srt[1][1], srt[2][1]),
                    mn(mn(srt[0][2], srt[1][2]), srt[2][2]));

  assign out_valid = v3;
endmodule

// File: rtl/impulse_denoise_chk.sv
`timescale 1ns/1ps
module impulse_denoise_chk #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eol
);
  int unsigned n_in, n_out;
  int col, row;
  logic ofire;
  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in <= 0; n_out <= 0; col <= 0; row <= 0;
    end else begin
      if (in_valid && in_ready) n_in <= n_in + 1;
      if (ofire) begin
        n_out <= n_out + 1;
        if (col == IMG_W - 1) begin
          col <= 0;
          row <= (row == IMG_H - 1) ? 0 : row + 1;
        end else col <= col + 1;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)));

  // R7
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofire |-> (out_sof == (col == 0 && row == 0)));

  // R7
  eol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofire |-> (out_eol == (col == IMG_W - 1)));

  // R10
  out_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofire |-> (n_out < n_in));
endmodule

bind impulse_denoise impulse_denoise_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eol(out_eol));

// File: tb/impulse_denoise_test.sv
`timescale 1ns/1ps
module impulse_denoise_test;
  localparam int W = 10;
  localparam int H = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] cfg_thresh, cfg_step, cfg_link;
  logic       cfg_two_pass;
  logic       in_valid, in_ready, out_ready, out_valid, out_sof, out_eol;
  logic [7:0] in_data, out_data;

  impulse_denoise #(.IMG_W(W), .IMG_H(H)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_step(cfg_step),
    .cfg_link(cfg_link), .cfg_two_pass(cfg_two_pass), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol));

  typedef struct { int d; bit sof; bit eol; string tag; } exp_t;
  exp_t q[$];
  int img [H][W];
  int ncmp = 0, nfail = 0, nout = 0;
  bit done = 0, hold = 0;
  int hold_d;

  task automatic check(bit ok, string tag, int act, int exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int px(int r, int c);
    if (r < 0) r = 0;
    if (r > H-1) r = H-1;
    if (c < 0) c = 0;
    if (c > W-1) c = W-1;
    return img[r][c];
  endfunction

  function automatic int nv(int v, bit inv);
    return inv ? 255 - v : v;
  endfunction

  function automatic bit fire_a(int r, int c, bit inv, int th);
    return nv(img[r][c], inv) >= th;
  endfunction

  function automatic bit fire_b(int r, int c, bit inv, int th, int st, int lk);
    int cnt = 0;
    int t1;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if ((dr != 0 || dc != 0) && nv(px(r+dr, c+dc), inv) >= th) cnt++;
    t1 = (th > st) ? th - st : 0;
    return nv(img[r][c], inv) + cnt * lk >= t1;
  endfunction

  function automatic int med9(int r, int c);
    int a[9];
    int t;
    for (int k = 0; k < 9; k++) a[k] = px(r + k/3 - 1, c + k%3 - 1);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    return a[4];
  endfunction

  task automatic send_frame(int th, int st, int lk, bit two, bit disturb);
    exp_t e;
    bit s1, p1, lnk;
    cfg_thresh = 8'(th); cfg_step = 8'(st); cfg_link = 8'(lk); cfg_two_pass = two;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        s1  = fire_a(r, c, 0, th);
        p1  = fire_a(r, c, 1, th);
        lnk = fire_b(r, c, 0, th, st, lk) || fire_b(r, c, 1, th, st, lk);
        e.d   = (s1 || p1 || (two && lnk)) ? med9(r, c) : img[r][c];
        e.sof = (r == 0 && c == 0);
        e.eol = (c == W-1);
        if (disturb)                                 e.tag = "R9";
        else if (r == 0 || c == 0 || r == H-1 || c == W-1) e.tag = "R6";
        else if (s1)                                 e.tag = "R3";
        else if (p1)                                 e.tag = "R4";
        else if (lnk)                                e.tag = "R5";
        else                                         e.tag = "R2";
        q.push_back(e);
      end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (((r*W + c) % 7) == 6) begin
          @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(img[r][c]);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        if (disturb && r == 0 && c == 0) begin
          @(posedge clk); #1;
          cfg_thresh = 8'd0; cfg_link = 8'd255; cfg_two_pass = 1'b1;
        end
      end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    exp_t e;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      #1;
      if (hold && !done) check(out_valid && out_data == hold_d, "R8", int'(out_data), hold_d);
      hold   = out_valid && !out_ready;
      hold_d = int'(out_data);
      if (out_valid && out_ready && !done) begin
        nout++;
        if (q.size() == 0) check(0, "R10 extra output", nout, 0);
        else begin
          e = q.pop_front();
          check(int'(out_data) == e.d, e.tag, int'(out_data), e.d);
          check(out_sof == e.sof && out_eol == e.eol, "R7", int'({out_sof, out_eol}),
                int'({e.sof, e.eol}));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      ncmp++; nfail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", nout, 5*W*H);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cfg_thresh = '0; cfg_step = '0; cfg_link = '0; cfg_two_pass = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R2: smooth ramp, nothing near either extreme
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 40 + r*20 + c*5;
    send_frame(250, 0, 0, 0, 0);

    // R3 R4 R6: salt and pepper, some on corners and edges
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 100 + (r + c) * 3;
    img[2][3] = 255; img[0][0] = 255; img[5][9] = 255; img[3][6] = 252;
    img[1][7] = 0;   img[4][2] = 3;   img[5][0] = 0;   img[0][9] = 0;
    send_frame(250, 0, 0, 0, 0);

    // R5: linked neighbours, one pass then two passes
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 120;
    img[2][4] = 255; img[2][5] = 228; img[3][4] = 228;
    img[3][8] = 0;   img[3][7] = 30;
    send_frame(240, 20, 10, 0, 0);
    send_frame(240, 20, 10, 1, 0);

    // R9: configuration disturbed after the first pixel
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 100 + (r + c) * 3;
    img[2][3] = 255; img[1][7] = 0; img[4][5] = 251;
    send_frame(250, 0, 0, 0, 1);

    while (q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(nout == 5*W*H, "R10 output count", nout, 5*W*H);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end
endmodule